// File: doc/BRIEF.md
# STN Panel Interface Controller

This block feeds a passive-matrix (STN) dot panel from a pixel source that can pause at any time. Each incoming stream item is one panel dot carrying a 2-bit grey level. In monochrome mode a dot is a pixel. In colour mode a dot is a single red, green or blue subpixel, and the source sends them in R, G, B order. The controller turns each dot into one on/off bit through two-frame temporal dithering. It then gathers four bits into a nibble and presents the nibble to the panel with a one-clock dot-latch strobe.

The panel's row register only collects these nibbles. A row becomes visible when the row-load pulse transfers the whole register at once. Because of this, nibble delivery within a row is elastic and simply follows the source's valid signal. Only the row-load pulse keeps a fixed period. A frame-start pulse marks the frame boundary. If a row is still incomplete when its load time comes, the pulse goes out on time anyway, the partial row is dropped, and a sticky underrun flag is raised.

A small two-state machine controls filling. In `ST_FILL` the controller accepts dots. It moves `ST_FILL -> ST_HOLD` when the last nibble of the row is packed. It moves `ST_HOLD -> ST_FILL` on the row-load boundary. On an underrun it takes the transition `ST_FILL -> ST_FILL` at the row-load boundary and restarts the row at dot 0.

Top module: `stn_panel_ctrl`

## Requirements
- R1: Four accepted dots form one nibble. The first dot of the group goes to `dot_data[3]` and the fourth to `dot_data[0]`. `dot_latch` is high for exactly one clock, in the cycle after the fourth dot is accepted, and `dot_data` is valid in that cycle.
- R2: With `cfg_color`=1 a row holds 3×`cfg_cols` dots, otherwise `cfg_cols` dots. Dots are packed in arrival order across nibble boundaries, so groups 0, 1 and 2 are {R0,G0,B0,R1}, {G1,B1,R2,G2} and {B2,R3,G3,B3}.
- R3: A dot is taken only in a cycle where both `pix_valid` and `pix_ready` are high. Idle cycles inside a row do not change the nibble contents.
- R4: `row_load` is a one-clock pulse that recurs every `cfg_row_period` clocks, whatever the fill state.
- R5: `frame_start` is high only together with the `row_load` that closes row `cfg_rows`-1. It therefore occurs on every `cfg_rows`-th row load.
- R6: Level 0 gives an off dot and levels 2 and 3 give an on dot. Level 1 is on only while `frame_parity` is 1. `frame_parity` is 0 after reset and toggles on each `frame_start`.
- R7: Once all groups of a row are latched, `pix_ready` stays low until the next `row_load`. No `dot_latch` coincides with a `row_load`, and every group of a row is latched before that row's load pulse.
- R8: If a row is incomplete at its load time, `underrun` rises together with that `row_load` and stays high until reset. The partially packed dots are discarded, and the next row starts at a fresh group with dot 0.
- R9: During and right after reset, `dot_latch`, `row_load`, `frame_start`, `underrun` and `frame_parity` are 0 and `pix_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_color | input | 1 | 1 selects colour subpixel mode |
| cfg_cols | input | COL_W | Pixel columns per row, a multiple of 4 |
| cfg_rows | input | ROW_W | Rows per frame |
| cfg_row_period | input | PER_W | Clocks between row-load pulses |
| pix_valid | input | 1 | Source has a dot |
| pix_level | input | 2 | Grey level of the dot |
| pix_ready | output | 1 | Controller can take a dot this cycle |
| dot_latch | output | 1 | Nibble strobe to the panel |
| dot_data | output | 4 | Four packed dot bits |
| row_load | output | 1 | Row transfer pulse |
| frame_start | output | 1 | Frame boundary pulse |
| frame_parity | output | 1 | Current dither frame |
| underrun | output | 1 | Sticky late-row flag |

## Verification
A dot taken at a clock edge shows up packed one cycle after its group's fourth dot is taken. The monitor pops the expected nibble at each falling edge where `dot_latch` is high, so every result is compared in the single cycle in which it is valid. `row_load`, `frame_start` and `underrun` all change at the same edge as the row boundary. They are checked at the falling edge where `row_load` is seen: the pulse spacing is counted against `cfg_row_period`, and at that point the expected-nibble queue must be empty. `pix_ready` is sampled at the falling edge right after the last accepted dot, which is the first cycle in which the hold state applies.

// File: rtl/stn_pkg.sv
package stn_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_HOLD = 1'b1
    } fill_state_t;
endpackage

// File: rtl/stn_row_timer.sv
module stn_row_timer #(
    parameter int ROW_W = 9,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [PER_W-1:0] cfg_period,
    output logic             row_end,
    output logic             row_load,
    output logic             frame_start,
    output logic             parity
);
    logic [PER_W-1:0] tick;
    logic [ROW_W-1:0] row_idx;
    logic             last_row;

    assign row_end  = (tick == cfg_period - PER_W'(1));
    assign last_row = (row_idx == cfg_rows - ROW_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick        <= '0;
            row_idx     <= '0;
            row_load    <= 1'b0;
            frame_start <= 1'b0;
            parity      <= 1'b0;
        end else begin
            row_load    <= row_end;
            frame_start <= row_end && last_row;
            if (row_end) begin
                tick    <= '0;
                row_idx <= last_row ? '0 : row_idx + ROW_W'(1);
                if (last_row)
                    parity <= ~parity;
            end else begin
                tick <= tick + PER_W'(1);
            end
        end
    end
endmodule

// File: rtl/stn_dot_packer.sv
module stn_dot_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [1:0] level,
    input  logic       parity,
    output logic       grp_full,
    output logic       grp_valid,
    output logic [3:0] grp_data
);
    logic [1:0] slot;
    logic [2:0] held;
    logic       dot_on;

    always_comb begin
        unique case (level)
            2'd0:    dot_on = 1'b0;
            2'd1:    dot_on = parity;
            default: dot_on = 1'b1;
        endcase
    end

    assign grp_full = take && (slot == 2'd3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            held      <= '0;
            grp_valid <= 1'b0;
            grp_data  <= '0;
        end else begin
            grp_valid <= grp_full && !clear;
            if (grp_full && !clear)
                grp_data <= {held, dot_on};
            if (clear) begin
                slot <= '0;
                held <= '0;
            end else if (take) begin
                held <= {held[1:0], dot_on};
                slot <= slot + 2'd1;
            end
        end
    end
endmodule

// File: rtl/stn_panel_ctrl.sv
module stn_panel_ctrl
    import stn_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 9,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_color,
    input  logic [COL_W-1:0] cfg_cols,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [PER_W-1:0] cfg_row_period,
    input  logic             pix_valid,
    input  logic [1:0]       pix_level,
    output logic             pix_ready,
    output logic             dot_latch,
    output logic [3:0]       dot_data,
    output logic             row_load,
    output logic             frame_start,
    output logic             frame_parity,
    output logic             underrun
);
    localparam int DOT_W = COL_W + 2;

    fill_state_t      state, nxt;
    logic             row_end;
    logic             take;
    logic             grp_full;
    logic             row_done;
    logic [DOT_W-1:0] dots_per_row;
    logic [DOT_W-1:0] groups_per_row;
    logic [DOT_W-1:0] grp_cnt;

    stn_row_timer #(.ROW_W(ROW_W), .PER_W(PER_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_rows    (cfg_rows),
        .cfg_period  (cfg_row_period),
        .row_end     (row_end),
        .row_load    (row_load),
        .frame_start (frame_start),
        .parity      (frame_parity)
    );

    stn_dot_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (row_end),
        .take      (take),
        .level     (pix_level),
        .parity    (frame_parity),
        .grp_full  (grp_full),
        .grp_valid (dot_latch),
        .grp_data  (dot_data)
    );

    assign dots_per_row   = cfg_color ? DOT_W'(cfg_cols) * DOT_W'(3) : DOT_W'(cfg_cols);
    assign groups_per_row = dots_per_row >> 2;
    assign pix_ready      = (state == ST_FILL) && !row_end;
    assign take           = pix_valid && pix_ready;
    assign row_done       = grp_full && (grp_cnt == groups_per_row - DOT_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL: begin
                if (row_end)       nxt = ST_FILL;
                else if (row_done) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (row_end)       nxt = ST_FILL;
            end
            default:               nxt = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt  <= '0;
            underrun <= 1'b0;
        end else if (row_end) begin
            grp_cnt <= '0;
            if (state == ST_FILL)
                underrun <= 1'b1;
        end else if (grp_full) begin
            grp_cnt <= grp_cnt + DOT_W'(1);
        end
    end
endmodule

// File: rtl/stn_panel_chk.sv
module stn_panel_chk (
    input logic clk,
    input logic rst_n,
    input logic pix_ready,
    input logic dot_latch,
    input logic row_load,
    input logic frame_start,
    input logic underrun
);
    // R4
    row_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |=> !row_load);
    // R5
    frame_with_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> row_load);
    // R7
    latch_apart_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dot_latch && row_load));
    // R7
    no_ready_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |-> !$past(pix_ready));
    // R1
    latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dot_latch |=> !dot_latch);
    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R8
    underrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> row_load);
endmodule

bind stn_panel_ctrl stn_panel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_ready   (pix_ready),
    .dot_latch   (dot_latch),
    .row_load    (row_load),
    .frame_start (frame_start),
    .underrun    (underrun)
);

// File: tb/sim_stn_panel_ctrl.sv
module sim_stn_panel_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_color = 1'b0;
    logic [9:0]  cfg_cols = 10'd8;
    logic [8:0]  cfg_rows = 9'd3;
    logic [11:0] cfg_row_period = 12'd40;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_level = 2'd0;
    logic        pix_ready, dot_latch, row_load, frame_start, frame_parity, underrun;
    logic [3:0]  dot_data;

    int checks = 0;
    int errors = 0;
    int par = 0;
    int loads = 0;
    int lv[0:15];
    logic [3:0] q[$];

    stn_panel_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_color(cfg_color), .cfg_cols(cfg_cols),
        .cfg_rows(cfg_rows), .cfg_row_period(cfg_row_period), .pix_valid(pix_valid),
        .pix_level(pix_level), .pix_ready(pix_ready), .dot_latch(dot_latch),
        .dot_data(dot_data), .row_load(row_load), .frame_start(frame_start),
        .frame_parity(frame_parity), .underrun(underrun)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: nibbles
    always @(negedge clk) begin
        if (rst_n && dot_latch) begin
            if (q.size() == 0) begin
                chk(1'b0, "R1 unexpected latch", int'(dot_data), -1);
            end else begin
                logic [3:0] e;
                e = q.pop_front();
                chk(dot_data == e, "R1/R2/R3/R6 nibble", int'(dot_data), int'(e));
            end
        end
    end

    // row period monitor
    int since = 0;
    bit seen = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            since = 0;
            seen = 1'b0;
        end else begin
            since++;
            if (row_load) begin
                if (seen) chk(since == int'(cfg_row_period), "R4 row period", since, int'(cfg_row_period));
                seen = 1'b1;
                since = 0;
            end
        end
    end

    task automatic do_reset(input bit color, input int cols);
        @(negedge clk);
        rst_n = 1'b0;
        pix_valid = 1'b0;
        cfg_color = color;
        cfg_cols = 10'(cols);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        par = 0;
        loads = 0;
        q.delete();
    endtask

    function automatic int dot_bit(input int lvl, input int p);
        if (lvl == 0) return 0;
        if (lvl == 1) return p;
        return 1;
    endfunction

    // driver: push expected groups, then present n dots
    task automatic send_row(input int n, input int stall_mod, input bit full);
        for (int g = 0; g < n / 4; g++) begin
            logic [3:0] e;
            for (int k = 0; k < 4; k++) e[3-k] = 1'(dot_bit(lv[4*g+k], par));
            q.push_back(e);
        end
        for (int i = 0; i < n; i++) begin
            bit acc;
            if (stall_mod != 0 && (i % stall_mod) == stall_mod - 1) begin
                @(negedge clk);
                pix_valid = 1'b0;
            end
            do begin
                @(negedge clk);
                pix_valid = 1'b1;
                pix_level = 2'(lv[i]);
                acc = pix_ready;
            end while (!acc);
        end
        @(negedge clk);
        pix_valid = 1'b0;
        if (full) chk(pix_ready == 1'b0, "R7 ready low after full row", int'(pix_ready), 0);
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!row_load);
        loads++;
        chk(q.size() == 0, "R7 groups latched before load", q.size(), 0);
        chk(frame_start == ((loads % int'(cfg_rows)) == 0), "R5 frame start", int'(frame_start),
            int'((loads % int'(cfg_rows)) == 0));
        if (frame_start) par ^= 1;
        chk(int'(frame_parity) == par, "R6 parity", int'(frame_parity), par);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Test 1: monochrome, cols=8
        do_reset(1'b0, 8);
        @(negedge clk);
        chk(dot_latch == 0 && row_load == 0 && frame_start == 0, "R9 reset strobes", 0, 0);
        chk(underrun == 0 && frame_parity == 0, "R9 reset flags", int'(underrun), 0);
        chk(pix_ready == 1, "R9 reset ready", int'(pix_ready), 1);
        lv = '{2,0,2,2, 0,0,2,0, 0,0,0,0, 0,0,0,0};
        send_row(8, 3, 1'b1);            // R3 stalls
        wait_load();
        lv = '{1,1,1,1, 1,1,1,1, 0,0,0,0, 0,0,0,0};
        send_row(8, 0, 1'b1);            // R6 parity 0 -> off
        wait_load();
        lv = '{1,2,0,1, 2,1,1,0, 0,0,0,0, 0,0,0,0};
        send_row(8, 2, 1'b1);
        wait_load();                      // R5 frame start here
        lv = '{1,1,1,1, 1,1,1,1, 0,0,0,0, 0,0,0,0};
        send_row(8, 0, 1'b1);            // R6 parity 1 -> on
        wait_load();
        lv = '{0,1,2,3, 1,0,3,1, 0,0,0,0, 0,0,0,0};
        send_row(8, 4, 1'b1);
        wait_load();
        wait_load();                      // empty row: underrun expected
        chk(underrun == 1, "R8 empty row underrun", int'(underrun), 1);

        // Test 2: colour, cols=4 -> 12 subpixels
        do_reset(1'b1, 4);
        lv = '{2,0,0,2, 2,2,0,2, 0,0,2,2, 0,0,0,0};
        send_row(12, 5, 1'b1);           // R2 expects 1001,1101,0011
        wait_load();
        chk(underrun == 0, "R2 colour row complete", int'(underrun), 0);

        // Test 3: underrun with partial group discard
        do_reset(1'b0, 8);
        lv = '{2,2,0,0, 2,2,0,0, 0,0,0,0, 0,0,0,0};
        send_row(6, 0, 1'b0);
        wait_load();
        chk(underrun == 1, "R8 underrun rises with load", int'(underrun), 1);
        lv = '{2,2,2,2, 0,0,0,0, 0,0,0,0, 0,0,0,0};
        send_row(8, 0, 1'b1);            // R8 fresh group alignment
        wait_load();
        chk(underrun == 1, "R8 underrun sticky", int'(underrun), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule